// File: doc/BRIEF.md
# Programmable Interval Timer with Halfword Register Access

This peripheral holds a 32-bit up-counter behind a 16-bit register bus. Software writes a 32-bit terminal value as two halfwords, sets a clock divider, and then starts the counter in one of two modes. A single-run start counts from zero up to the terminal value and parks there. A repeating start counts from zero to the terminal value, wraps to zero and keeps going. Each time the counter meets the terminal value a sticky event flag is set. When interrupts are enabled, that flag drives a level interrupt line.

The divider sets how many clock cycles make one count step. It is programmed as the ratio minus one, so a value of 8 yields one step every nine clocks. Reads of the running count are split into halfwords. A read of the lower half also latches the upper half into a holding register, so that a lower-then-upper read pair always returns one consistent 32-bit value. Terminal values below two are raised to two, which means a run never completes in fewer than three count steps.

Register offsets (byte addresses): control 0x00, terminal low 0x08, terminal high 0x0C, count low 0x10, count high 0x14, divider 0x18.

Top module: `interval_timer`

## Requirements
- R1: After reset, every register reads zero, the count reads zero and irq is low.
- R2: Control bit 0 (repeat), bit 1 (single run) and bit 8 (interrupt enable) read back as written at 0x00, and all other control bits read zero. The terminal halves at 0x08/0x0C and the divider at 0x18 read back the last value written.
- R3: A control write with bit 1 set and bit 0 clear zeroes the count and starts a single run. The count rises by one per step. On the step taken while the count equals the terminal value, the count stays there, the counter stops and the event flag is set.
- R4: A control write with bit 0 set zeroes the count and starts repeating operation. On the step taken while the count equals the terminal value, the count goes to 0, the event flag is set, and counting continues. Bit 0 takes precedence over bit 1.
- R5: With divider value D, the count advances once every D+1 clock cycles. The first step comes D+1 cycles after the starting control write.
- R6: A write to the divider register restarts the divider phase, so the next step comes D+1 cycles after that write.
- R7: A terminal value below 2 acts as 2, so a single run sets the event flag on its third step.
- R8: irq is a level equal to (event flag AND control bit 8). It stays high until the next control write, and every control write clears the flag.
- R9: A control write with bits 0 and 1 both clear stops the counter and freezes the count at its current value. While stopped, the count does not change.
- R10: A read of 0x10 returns count bits 15:0 and latches count bits 31:16. A read of 0x14 returns the latched value.
- R11: Reads of offsets outside the register map return zero, and writes to those offsets change no register.
- R12: With control bit 8 clear, irq stays low even when a run reaches its terminal value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_rd | input | 1 | Register read strobe, one cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after bus_rd |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: 16-bit data, a 5-bit address, a 16-bit divider and a minimum run of three steps. With these values a carry out of the lower count half happens after 65,536 steps. The bench reaches that point in a single pass, which lets it show that the latched upper half does not tear across the carry. The small divider ratios it uses expose the step phase and the phase restart one cycle at a time. The minimum-run clamp is exercised at a terminal value of zero, one step on each side of completion.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 5,
  parameter int DIV_W     = 16,
  parameter int MIN_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;
  localparam logic [CNT_W-1:0]  MIN_LIM   = CNT_W'(MIN_TICKS - 1);
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_LIM_LO  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_LIM_HI  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_CNT_LO  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_CNT_HI  = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_DIV     = ADDR_W'(8'h18);

  logic              ctrl_rep, ctrl_one, ctrl_ie;
  logic [CNT_W-1:0]  limit, count, eff_lim;
  logic [DIV_W-1:0]  divider, phase;
  logic [DATA_W-1:0] shadow, ctrl_rd;
  logic              running, periodic, pend;
  logic              ctrl_wr, div_wr, step_due, tick, hit, start;

  assign ctrl_wr  = bus_wr && (bus_addr == A_CTRL);
  assign div_wr   = bus_wr && (bus_addr == A_DIV);
  assign start    = bus_wdata[0] || bus_wdata[1];
  assign step_due = (phase == divider);
  assign tick     = running && step_due;
  assign eff_lim  = (limit < MIN_LIM) ? MIN_LIM : limit;
  assign hit      = tick && (count == eff_lim);
  assign irq      = pend && ctrl_ie;

  always_comb begin
    ctrl_rd    = '0;
    ctrl_rd[0] = ctrl_rep;
    ctrl_rd[1] = ctrl_one;
    ctrl_rd[8] = ctrl_ie;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_rep <= 1'b0;
      ctrl_one <= 1'b0;
      ctrl_ie  <= 1'b0;
    end else if (ctrl_wr) begin
      ctrl_rep <= bus_wdata[0];
      ctrl_one <= bus_wdata[1];
      ctrl_ie  <= bus_wdata[8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit   <= '0;
      divider <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_LIM_LO) limit[DATA_W-1:0]     <= bus_wdata;
      if (bus_addr == A_LIM_HI) limit[CNT_W-1:DATA_W] <= bus_wdata;
      if (bus_addr == A_DIV)    divider               <= DIV_W'(bus_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 phase <= '0;
    else if (ctrl_wr || div_wr) phase <= '0;
    else if (step_due)          phase <= '0;
    else                        phase <= phase + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      running  <= 1'b0;
      periodic <= 1'b0;
      pend     <= 1'b0;
    end else if (ctrl_wr) begin
      pend    <= 1'b0;
      running <= start;
      if (start) begin
        count    <= '0;
        periodic <= bus_wdata[0];
      end
    end else if (hit) begin
      pend <= 1'b1;
      if (periodic) count   <= '0;
      else          running <= 1'b0;
    end else if (tick) begin
      count <= count + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      shadow    <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_CTRL:   bus_rdata <= ctrl_rd;
        A_LIM_LO: bus_rdata <= limit[DATA_W-1:0];
        A_LIM_HI: bus_rdata <= limit[CNT_W-1:DATA_W];
        A_CNT_LO: begin
          bus_rdata <= count[DATA_W-1:0];
          shadow    <= count[CNT_W-1:DATA_W];
        end
        A_CNT_HI: bus_rdata <= shadow;
        A_DIV:    bus_rdata <= DATA_W'(divider);
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic                irq,
  input logic                ctrl_ie,
  input logic [2*DATA_W-1:0] count,
  input logic [2*DATA_W-1:0] eff_lim,
  input logic                running,
  input logic                periodic,
  input logic                tick
);
  localparam int CNT_W = 2 * DATA_W;
  logic mapped;
  assign mapped = (bus_addr == ADDR_W'(8'h00)) || (bus_addr == ADDR_W'(8'h08)) ||
                  (bus_addr == ADDR_W'(8'h0C)) || (bus_addr == ADDR_W'(8'h10)) ||
                  (bus_addr == ADDR_W'(8'h14)) || (bus_addr == ADDR_W'(8'h18));

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl_ie); // R12
  AST_CTRL_WRITE_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == '0) |=> !irq); // R8
  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !periodic && tick && count == eff_lim && !bus_wr) |=> !running); // R3
  AST_PERIODIC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && periodic && tick && count == eff_lim && !bus_wr) |=> (count == '0 && running)); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && count != eff_lim && !bus_wr) |=> count == $past(count) + CNT_W'(1)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !bus_wr) |=> $stable(count)); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !mapped) |=> bus_rdata == '0); // R11
endmodule

bind interval_timer interval_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq(irq), .ctrl_ie(ctrl_ie), .count(count), .eff_lim(eff_lim),
  .running(running), .periodic(periodic), .tick(tick)
);

// File: tb/interval_timer_tb.sv
module interval_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  logic [15:0] rd;

  always #2 clk = ~clk;

  interval_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct packed {
    logic [15:0] div;
    logic [31:0] lim;
    logic        rep;
    logic [31:0] wait_n;
    logic [31:0] exp_cnt;
    logic        exp_irq;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{16'd0, 32'd10, 1'b0, 32'd4,  32'd4,  1'b0},
    '{16'd0, 32'd10, 1'b0, 32'd20, 32'd10, 1'b1},
    '{16'd0, 32'd5,  1'b1, 32'd8,  32'd2,  1'b1},
    '{16'd2, 32'd10, 1'b0, 32'd7,  32'd2,  1'b0},
    '{16'd1, 32'd3,  1'b1, 32'd9,  32'd0,  1'b1},
    '{16'd0, 32'd0,  1'b0, 32'd2,  32'd2,  1'b0},
    '{16'd0, 32'd0,  1'b0, 32'd3,  32'd2,  1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [4:0] a, output logic [15:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    check("R1 irq", {31'b0, irq}, 0);
    rdreg(5'h00, rd); check("R1 ctrl", {16'b0, rd}, 0);
    rdreg(5'h08, rd); check("R1 lim lo", {16'b0, rd}, 0);
    rdreg(5'h0C, rd); check("R1 lim hi", {16'b0, rd}, 0);
    rdreg(5'h18, rd); check("R1 div", {16'b0, rd}, 0);
    rdreg(5'h10, rd); check("R1 cnt lo", {16'b0, rd}, 0);
    rdreg(5'h14, rd); check("R1 cnt hi", {16'b0, rd}, 0);

    wr(5'h00, 16'hFFFF);
    rdreg(5'h00, rd); check("R2 ctrl", {16'b0, rd}, 32'h0103);
    wr(5'h00, 16'h0000);
    wr(5'h08, 16'hBEEF); wr(5'h0C, 16'h1234); wr(5'h18, 16'h0005);
    rdreg(5'h08, rd); check("R2 lim lo", {16'b0, rd}, 32'hBEEF);
    rdreg(5'h0C, rd); check("R2 lim hi", {16'b0, rd}, 32'h1234);
    rdreg(5'h18, rd); check("R2 div", {16'b0, rd}, 32'h0005);

    wr(5'h04, 16'hFFFF);
    wr(5'h1C, 16'hFFFF);
    rdreg(5'h04, rd); check("R11 read 04", {16'b0, rd}, 0);
    rdreg(5'h1C, rd); check("R11 read 1C", {16'b0, rd}, 0);
    rdreg(5'h08, rd); check("R11 lim lo kept", {16'b0, rd}, 32'hBEEF);
    rdreg(5'h0C, rd); check("R11 lim hi kept", {16'b0, rd}, 32'h1234);
    rdreg(5'h18, rd); check("R11 div kept", {16'b0, rd}, 32'h0005);

    for (int i = 0; i < 7; i++) begin
      logic [15:0] lo, hi;
      wr(5'h00, 16'h0000);
      wr(5'h18, VECS[i].div);
      wr(5'h08, VECS[i].lim[15:0]);
      wr(5'h0C, VECS[i].lim[31:16]);
      wr(5'h00, VECS[i].rep ? 16'h0101 : 16'h0102);
      idle(int'(VECS[i].wait_n));
      check($sformatf("R3/R4/R5/R7/R8 vec %0d irq", i), {31'b0, irq}, {31'b0, VECS[i].exp_irq});
      rdreg(5'h10, lo);
      rdreg(5'h14, hi);
      check($sformatf("R3/R4/R5/R7 vec %0d count", i), {hi, lo}, VECS[i].exp_cnt);
    end

    wr(5'h00, 16'h0000); wr(5'h18, 16'h0000);
    wr(5'h08, 16'h0004); wr(5'h0C, 16'h0000);
    wr(5'h00, 16'h0002);
    idle(10);
    check("R12 irq masked", {31'b0, irq}, 0);
    rdreg(5'h10, rd); check("R12 count at limit", {16'b0, rd}, 4);

    wr(5'h00, 16'h0102);
    idle(10);
    check("R8 irq set", {31'b0, irq}, 1);
    idle(20);
    check("R8 irq held", {31'b0, irq}, 1);
    wr(5'h00, 16'h0000);
    check("R8 irq cleared by ctrl write", {31'b0, irq}, 0);

    wr(5'h08, 16'd1000);
    wr(5'h00, 16'h0001);
    idle(20);
    wr(5'h00, 16'h0000);
    idle(10);
    rdreg(5'h10, rd); check("R9 frozen count", {16'b0, rd}, 20);
    idle(10);
    rdreg(5'h10, rd); check("R9 still frozen", {16'b0, rd}, 20);
    wr(5'h00, 16'h0001);
    idle(5);
    rdreg(5'h10, rd); check("R9 restart from zero", {16'b0, rd}, 5);

    wr(5'h00, 16'h0000);
    wr(5'h18, 16'h0003);
    wr(5'h00, 16'h0001);
    idle(2);
    wr(5'h18, 16'h0003);
    idle(3);
    rdreg(5'h10, rd); check("R6 phase restarted", {16'b0, rd}, 0);
    rdreg(5'h14, rd);
    rdreg(5'h10, rd); check("R6 step after restart", {16'b0, rd}, 1);

    wr(5'h00, 16'h0000);
    wr(5'h18, 16'h0000);
    wr(5'h08, 16'h0000); wr(5'h0C, 16'h0002);
    wr(5'h00, 16'h0002);
    idle(65535);
    rdreg(5'h10, rd); check("R10 low before carry", {16'b0, rd}, 32'hFFFF);
    rdreg(5'h14, rd); check("R10 latched high", {16'b0, rd}, 0);
    rdreg(5'h10, rd); check("R10 low after carry", {16'b0, rd}, 1);
    rdreg(5'h14, rd); check("R10 high after carry", {16'b0, rd}, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule